// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC. It looks at the destination address of each incoming frame and decides whether the frame should be kept or dropped. The six address bytes arrive one per clock with `byte_valid`. The first byte is marked by `byte_start`. Exactly one cycle after the sixth byte is taken, the block pulses `decision_valid` and drives `accept` with its verdict.

Four sources can admit a frame, and they are checked in a fixed priority:

- **Promiscuous mode** admits everything.
- **The all-ones broadcast address** is admitted unless broadcast rejection is set.
- **Other group (multicast) addresses** are looked up in a 64-entry hash bitmap. The bitmap is indexed by six bits of a CRC-32 over the address.
- **Individual (unicast) addresses** must equal the programmed station address.

The station address is spread over a 32-bit word and a 16-bit word, in the layout given in R3. All configuration inputs are static levels supplied by the surrounding register file.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `decision_valid` and `accept` are both 0 until an address has been received.
- R2: `decision_valid` is high for exactly one cycle, namely the cycle after the edge that takes the sixth address byte. Cycles with `byte_valid` low between bytes are not counted as bytes.
- R3: An individual address (bit 0 of the first byte is 0) is accepted only when all six bytes equal the station address. The station bytes are:
  - byte 0 = `station_hi[15:8]`
  - byte 1 = `station_hi[7:0]`
  - byte 2 = `station_lo[31:24]`
  - byte 3 = `station_lo[23:16]`
  - byte 4 = `station_lo[15:8]`
  - byte 5 = `station_lo[7:0]`
- R4: The address FF:FF:FF:FF:FF:FF, when `promisc` is 0, is accepted exactly when `bcast_reject` is 0, whatever the hash bitmap holds.
- R5: A group address other than broadcast (bit 0 of byte 0 is 1) is accepted exactly when its hash bit is 1. The hash index comes from a CRC-32 over the six bytes, with these rules:
  - bytes are processed in arrival order, each least-significant bit first;
  - the CRC register starts at 0xFFFFFFFF and uses the reflected polynomial 0xEDB88320;
  - the index is register bits 31:26, taken without final inversion.
  Index bit 5 = 1 selects `hash_hi` and 0 selects `hash_lo`; index bits 4:0 pick the bit within that word.
- R6: With both hash words all ones, every group address is accepted.
- R7: With `promisc` = 1, every address is accepted.
- R8: `byte_start` always restarts the address at byte 0, even part-way through an address. Valid bytes after the sixth are ignored and produce no decision until the next `byte_start`.
- R9: `accept` is 0 in every cycle in which `decision_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | An address byte is present on `byte_data` |
| byte_start | input | 1 | The present byte is the first address byte (qualified by `byte_valid`) |
| byte_data | input | 8 | Address byte |
| station_lo | input | 32 | Station address bytes 2..5, byte 2 in the top bits |
| station_hi | input | 16 | Station address bytes 0..1, byte 0 in the top bits |
| hash_lo | input | 32 | Hash bitmap word for indices 0..31 |
| hash_hi | input | 32 | Hash bitmap word for indices 32..63 |
| promisc | input | 1 | Accept every address |
| bcast_reject | input | 1 | Reject the broadcast address |
| decision_valid | output | 1 | One-cycle pulse carrying the verdict |
| accept | output | 1 | Verdict: 1 keeps the frame |

## Verification
Some properties are checked on every cycle by the bound checker:
- the pulse comes exactly one cycle after the internal last-byte event, and at no other time;
- `accept` is never high outside the pulse;
- promiscuous mode always accepts;
- the broadcast verdict follows `bcast_reject`.

Other behaviour can only be shown by the bench's sweeps, which compute expected verdicts with an independently formulated CRC. These cover:
- the correctness of the hash index and of the `hash_lo`/`hash_hi` word selection;
- the byte order of the station compare;
- the restart on `byte_start` and the ignoring of surplus bytes.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB8_8320;
  localparam int unsigned HASH_IDX_W = 6;
  localparam int unsigned HASH_WORD_W = 32;

  // Advance a reflected CRC-32 register by one byte, LSB first.
  function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] c,
                                                      input logic [7:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

  // Station byte k in arrival order from the split register pair.
  function automatic logic [7:0] station_byte(input logic [31:0] lo,
                                              input logic [15:0] hi,
                                              input logic [2:0] k);
    case (k)
      3'd0:    return hi[15:8];
      3'd1:    return hi[7:0];
      3'd2:    return lo[31:24];
      3'd3:    return lo[23:16];
      3'd4:    return lo[15:8];
      default: return lo[7:0];
    endcase
  endfunction

  // Hash index taken from the top bits of the un-inverted CRC register.
  function automatic logic [HASH_IDX_W-1:0] hash_index(input logic [CRC_W-1:0] c);
    return c[CRC_W-1 -: HASH_IDX_W];
  endfunction

  // Top index bit picks the word, the rest picks the bit.
  function automatic logic hash_pick(input logic [HASH_WORD_W-1:0] lo,
                                     input logic [HASH_WORD_W-1:0] hi,
                                     input logic [HASH_IDX_W-1:0] idx);
    logic [HASH_IDX_W-2:0] b;
    b = idx[HASH_IDX_W-2:0];
    return idx[HASH_IDX_W-1] ? hi[b] : lo[b];
  endfunction
endpackage

// File: rtl/rxaf_byte_tracker.sv
module rxaf_byte_tracker #(
  parameter int unsigned ADDR_BYTES = 6,
  localparam int unsigned POS_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_valid,
  input  logic             byte_start,
  output logic             take,
  output logic             first,
  output logic             last,
  output logic [POS_W-1:0] cur_pos
);
  localparam logic [POS_W-1:0] IDLE_POS = POS_W'(ADDR_BYTES);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(ADDR_BYTES - 1);

  logic [POS_W-1:0] pos_q;

  always_comb begin
    cur_pos = byte_start ? '0 : pos_q;
    take    = byte_valid && (byte_start || (pos_q < IDLE_POS));
    first   = take && byte_start;
    last    = take && (cur_pos == LAST_POS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    pos_q <= IDLE_POS;
    else if (take) pos_q <= cur_pos + POS_W'(1);
  end
endmodule

// File: rtl/rxaf_crc_acc.sv
module rxaf_crc_acc
  import rxaf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             first,
  input  logic [7:0]       data,
  output logic [CRC_W-1:0] crc_nx
);
  logic [CRC_W-1:0] crc_q;

  always_comb crc_nx = crc_step_byte(first ? CRC_SEED : crc_q, data);

  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= CRC_SEED;
    else if (take) crc_q <= crc_nx;
  end
endmodule

// File: rtl/rxaf_classify.sv
module rxaf_classify
  import rxaf_pkg::*;
#(
  parameter int unsigned POS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             first,
  input  logic [POS_W-1:0] cur_pos,
  input  logic [7:0]       data,
  input  logic [31:0]      station_lo,
  input  logic [15:0]      station_hi,
  output logic             is_station,
  output logic             is_bcast,
  output logic             is_group
);
  logic eq_q, bc_q, grp_q;
  logic [7:0] want;

  always_comb begin
    want       = station_byte(station_lo, station_hi, 3'(cur_pos));
    is_station = (first ? 1'b1 : eq_q) && (data == want);
    is_bcast   = (first ? 1'b1 : bc_q) && (data == 8'hFF);
    is_group   = first ? data[0] : grp_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eq_q  <= 1'b0;
      bc_q  <= 1'b0;
      grp_q <= 1'b0;
    end else if (take) begin
      eq_q  <= is_station;
      bc_q  <= is_bcast;
      grp_q <= is_group;
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxaf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  localparam int unsigned POS_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_valid,
  input  logic        byte_start,
  input  logic [7:0]  byte_data,
  input  logic [31:0] station_lo,
  input  logic [15:0] station_hi,
  input  logic [31:0] hash_lo,
  input  logic [31:0] hash_hi,
  input  logic        promisc,
  input  logic        bcast_reject,
  output logic        decision_valid,
  output logic        accept
);
  logic                  take, first, last_byte;
  logic [POS_W-1:0]      cur_pos;
  logic [CRC_W-1:0]      crc_nx;
  logic                  is_station, is_bcast, is_group;
  logic [HASH_IDX_W-1:0] hidx;
  logic                  hash_hit, verdict;
  logic                  valid_q, accept_q;

  rxaf_byte_tracker #(.ADDR_BYTES(ADDR_BYTES)) u_trk (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_start(byte_start),
    .take(take), .first(first), .last(last_byte), .cur_pos(cur_pos)
  );

  rxaf_crc_acc u_crc (
    .clk(clk), .rst_n(rst_n), .take(take), .first(first),
    .data(byte_data), .crc_nx(crc_nx)
  );

  rxaf_classify #(.POS_W(POS_W)) u_cls (
    .clk(clk), .rst_n(rst_n), .take(take), .first(first), .cur_pos(cur_pos),
    .data(byte_data), .station_lo(station_lo), .station_hi(station_hi),
    .is_station(is_station), .is_bcast(is_bcast), .is_group(is_group)
  );

  always_comb begin
    hidx     = hash_index(crc_nx);
    hash_hit = hash_pick(hash_lo, hash_hi, hidx);
    if (promisc)       verdict = 1'b1;
    else if (is_bcast) verdict = !bcast_reject;
    else if (is_group) verdict = hash_hit;
    else               verdict = is_station;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      accept_q <= 1'b0;
    end else begin
      valid_q  <= last_byte;
      accept_q <= last_byte && verdict;
    end
  end

  assign decision_valid = valid_q;
  assign accept         = accept_q;
endmodule

// File: rtl/rxaf_checker.sv
module rxaf_checker (
  input logic clk,
  input logic rst_n,
  input logic last_byte,
  input logic is_bcast,
  input logic promisc,
  input logic bcast_reject,
  input logic decision_valid,
  input logic accept
);
  a_r2_pulse_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte |=> decision_valid);
  a_r8_no_pulse_without_last: assert property (@(posedge clk) disable iff (!rst_n)
    !last_byte |=> !decision_valid);
  a_r9_accept_only_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !decision_valid |-> !accept);
  a_r7_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && promisc) |=> accept);
  a_r4_bcast_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && !promisc && is_bcast && bcast_reject) |=> !accept);
  a_r4_bcast_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && !promisc && is_bcast && !bcast_reject) |=> accept);
endmodule

bind rx_addr_filter rxaf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .last_byte(last_byte), .is_bcast(is_bcast),
  .promisc(promisc), .bcast_reject(bcast_reject),
  .decision_valid(decision_valid), .accept(accept)
);

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic byte_valid = 1'b0, byte_start = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic [31:0] station_lo = 32'h0, hash_lo = 32'h0, hash_hi = 32'h0;
  logic [15:0] station_hi = 16'h0;
  logic promisc = 1'b0, bcast_reject = 1'b0;
  logic decision_valid, accept;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter uut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_start(byte_start),
    .byte_data(byte_data), .station_lo(station_lo), .station_hi(station_hi),
    .hash_lo(hash_lo), .hash_hi(hash_hi), .promisc(promisc),
    .bcast_reject(bcast_reject), .decision_valid(decision_valid), .accept(accept)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Forward (non-reflected) CRC-32, bits fed LSB first; index is the mirror of its low bits.
  function automatic logic [5:0] ref_index(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] b = a[47-8*k -: 8];
      for (int i = 0; i < 8; i++) begin
        logic top = c[31] ^ b[i];
        c = c << 1;
        if (top) c = c ^ 32'h04C1_1DB7;
      end
    end
    return {c[0], c[1], c[2], c[3], c[4], c[5]};
  endfunction

  function automatic logic model(input logic [47:0] a);
    logic [5:0] ix;
    if (promisc) return 1'b1;
    if (a == 48'hFFFF_FFFF_FFFF) return !bcast_reject;
    if (a[40]) begin
      ix = ref_index(a);
      return ix[5] ? hash_hi[ix[4:0]] : hash_lo[ix[4:0]];
    end
    return a == {station_hi, station_lo};
  endfunction

  // Sends six bytes (gap idle cycles between bytes), checks timing and verdict.
  task automatic send(input logic [47:0] a, input int gap, input string req);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      byte_valid = 1'b1; byte_start = (k == 0); byte_data = a[47-8*k -: 8];
      if (k == 5) chk({req, "/R2 no early pulse"}, decision_valid, 1'b0);
      for (int g = 0; g < gap && k < 5; g++) begin
        @(negedge clk);
        byte_valid = 1'b0; byte_start = 1'b0;
        chk("R2 no pulse in gap", decision_valid, 1'b0);
      end
    end
    @(negedge clk);
    byte_valid = 1'b0; byte_start = 1'b0;
    chk({req, "/R2 pulse"}, decision_valid, 1'b1);
    chk(req, accept, model(a));
    @(negedge clk);
    chk("R2 single-cycle pulse", decision_valid, 1'b0);
    chk("R9 accept low outside pulse", accept, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [47:0] st;
    st = 48'h0211_2233_4455;
    station_hi = st[47:32]; station_lo = st[31:0];
    repeat (3) @(negedge clk);
    chk("R1 reset valid", decision_valid, 1'b0);
    chk("R1 reset accept", accept, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle valid", decision_valid, 1'b0);

    // R3 station match, each byte mismatched, and a sweep of the last byte
    send(st, 0, "R3 exact station");
    for (int k = 0; k < 6; k++) send(st ^ (48'h02 << (8*k)), 0, "R3 one byte off");
    for (int v = 0; v < 256; v++) send({st[47:8], 8'(v)}, 0, "R3 last byte sweep");
    send(st, 2, "R3 station with gaps");

    // R5 hash sweep with two patterns (catches word/bit selection errors)
    hash_lo = 32'hA5C3_0F96; hash_hi = 32'h3C5A_F00F;
    for (int v = 0; v < 256; v++) send({40'h01_005E_0000, 8'(v)}, 0, "R5 hash sweep A");
    hash_lo = 32'h3C5A_F00F; hash_hi = 32'hA5C3_0F96;
    for (int v = 0; v < 256; v++) send({8'(v) | 8'h01, 40'h00_5E12_3456}, 0, "R5 hash sweep B");
    send({8'h03, 40'h0}, 1, "R5 group with gap");

    // R4 broadcast versus reject and hash contents
    for (int m = 0; m < 4; m++) begin
      bcast_reject = m[0];
      hash_lo = m[1] ? 32'hFFFF_FFFF : 32'h0; hash_hi = hash_lo;
      send(48'hFFFF_FFFF_FFFF, 0, "R4 broadcast");
    end
    bcast_reject = 1'b0;

    // R6 all-ones bitmap admits any group address
    hash_lo = 32'hFFFF_FFFF; hash_hi = 32'hFFFF_FFFF;
    for (int v = 0; v < 32; v++) begin
      logic [47:0] ga = {8'h01 | 8'(v*6), 8'(v*37), 32'(v*32'h9E37_79B9)};
      send(ga, 0, "R6 all-ones hash");
      chk("R6 accepted", model(ga), 1'b1);
    end
    hash_lo = 32'h0; hash_hi = 32'h0;

    // R7 promiscuous
    promisc = 1'b1; bcast_reject = 1'b1;
    send(48'h1234_5678_9ABC, 0, "R7 promisc unicast");
    send(48'h0100_5E00_0001, 0, "R7 promisc group");
    send(48'hFFFF_FFFF_FFFF, 0, "R7 promisc broadcast");
    promisc = 1'b0; bcast_reject = 1'b0;

    // R8 restart mid-address: three stray bytes then a full station address
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      byte_valid = 1'b1; byte_start = (k == 0); byte_data = 8'hEE;
    end
    send(st, 0, "R8 restart");
    // R8 surplus bytes ignored
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      byte_valid = 1'b1; byte_start = 1'b0; byte_data = 8'(k);
      if (k > 0) chk("R8 surplus byte ignored", decision_valid, 1'b0);
    end
    @(negedge clk);
    byte_valid = 1'b0;
    chk("R8 surplus final", decision_valid, 1'b0);
    send(st, 0, "R8 next frame after surplus");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule